// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block receives asynchronous serial characters from a single line and presents them to a host. A frame is a low start bit, then eight or nine data bits sent least significant bit first, then a stop bit. The frame size is chosen per frame by a mode input. The line is synchronised to the core clock. The receiver runs from an oversampling tick that the host supplies, and it decides each bit by a majority vote of three samples taken around the bit centre.

A frame whose start bit, data bits and stop-bit position are all zero is classed as a break character. A break sets the framing-error flag, the receiver-full flag and a separate break flag. It also forces the stored data byte and the stored ninth bit to zero. A zero stop bit with any non-zero data bit gives a framing error only.

The receiver-full flag gates overrun detection. If a frame completes while the previous frame has not yet been acknowledged, the overrun flag is set and the earlier frame stays in place. A single acknowledge pulse clears the receiver-full, framing-error, break and overrun flags together. A busy output shows when a character is being received.

Top module: `uart_brk_rx`

## Requirements
- R1: After reset, `data_o` is 0, `bit9_o` is 0, and `full_o`, `frame_err_o`, `brk_o`, `ovr_o` and `busy_o` are all 0.
- R2: A frame is a start bit of 0, then data bits least significant bit first, then a stop bit. There are 8 data bits when `nine_bit_i`=0 and 9 data bits when `nine_bit_i`=1. `data_o` holds data bits 0..7. `bit9_o` holds data bit 8 in 9-bit mode and is 0 in 8-bit mode. `full_o` is set when the stop bit is sampled.
- R3: Each bit value is the majority of three samples. The samples are taken at oversample ticks OVS/2-1, OVS/2 and OVS/2+1, counted from the tick at which the line was first seen low. A single inverted sample therefore does not change the bit. If the majority for the start bit reads 1, the start bit is discarded and no output changes.
- R4: If the stop sample is 0 and at least one data bit is 1 (bit 8 included in 9-bit mode), `frame_err_o` is set, `brk_o` stays 0, and the data is stored as received.
- R5: If the stop sample is 0 and all data bits are 0, the frame is a break. A break sets `frame_err_o`, `full_o` and `brk_o`, and sets `data_o` and `bit9_o` to 0.
- R6: `busy_o` is 1 from the validated start-bit vote until the stop-bit sample. It is 0 while the line is idle and after a rejected start bit.
- R7: If a frame completes while `full_o` is 1 and `ack_i` is 0, `ovr_o` is set. In that case `data_o`, `bit9_o`, `frame_err_o` and `brk_o` keep the values from the earlier frame.
- R8: An `ack_i` pulse clears `full_o`, `frame_err_o`, `brk_o` and `ovr_o`. A frame that completes in the same cycle as `ack_i` is handled as if it arrived after the clear.
- R9: A frame with all-zero data and a stop sample of 1 is a normal character. It sets only `full_o` and stores 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick enable, OVS ticks per bit |
| rxd_i | input | 1 | Serial receive line, idle high |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| ack_i | input | 1 | Pulse that clears the received-frame flags |
| data_o | output | DATA_W | Received data bits 0..7 |
| bit9_o | output | 1 | Received ninth data bit |
| full_o | output | 1 | Receiver full |
| frame_err_o | output | 1 | Framing error |
| brk_o | output | 1 | Break character received |
| ovr_o | output | 1 | Overrun |
| busy_o | output | 1 | Reception in progress |

## Verification
The bench builds the block with OVS=16 and DATA_W=8, and holds the tick high every clock, so one bit lasts sixteen clocks. This lets the bench place a single inverted sample inside the three-sample vote window, and a short low pulse that fails start-bit validation, at exact clock offsets. With DATA_W=8 both frame sizes can be exercised: break detection in 8-bit and 9-bit mode, the ninth data bit alone defeating a break, and the ninth bit being ignored in 8-bit mode.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/rx_vote.sv
module rx_vote #(
  parameter int OVS  = 16,
  parameter int PH_W = $clog2(OVS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic            rxd_i,
  output logic            vld_o,
  output logic            bit_o
);
  localparam int MID = OVS / 2;
  localparam logic [PH_W-1:0] PH_A = PH_W'(MID - 1);
  localparam logic [PH_W-1:0] PH_B = PH_W'(MID);
  localparam logic [PH_W-1:0] PH_C = PH_W'(MID + 1);

  logic s_a, s_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else if (tick_i) begin
      if (phase_i == PH_A) s_a <= rxd_i;
      if (phase_i == PH_B) s_b <= rxd_i;
    end
  end

  // third sample taken live at the voting tick
  assign vld_o = tick_i && (phase_i == PH_C);
  assign bit_o = (s_a & s_b) | (s_a & rxd_i) | (s_b & rxd_i);
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_brk_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8,
  parameter int PH_W   = $clog2(OVS),
  parameter int FRM_W  = DATA_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rxd_i,
  input  logic             nine_bit_i,
  input  logic             vld_i,
  input  logic             bit_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             stop_o,
  output logic [FRM_W-1:0] bits_o
);
  localparam int CNT_W = $clog2(FRM_W + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nbits;

  assign nbits = nine_bit_i ? CNT_W'(FRM_W) : CNT_W'(DATA_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= RX_IDLE;
      phase_o <= '0;
      cnt     <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      stop_o  <= 1'b1;
      bits_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        if (state == RX_IDLE) begin
          if (!rxd_i) begin
            state   <= RX_START;
            phase_o <= PH_W'(1);
            cnt     <= '0;
            bits_o  <= '0;
          end
        end else begin
          phase_o <= (phase_o == PH_LAST) ? '0 : phase_o + PH_W'(1);
          if (vld_i) begin
            case (state)
              RX_START: begin
                if (bit_i) state  <= RX_IDLE;  // false start
                else       busy_o <= 1'b1;
              end
              RX_DATA: begin
                bits_o[cnt] <= bit_i;
                cnt         <= cnt + CNT_W'(1);
              end
              RX_STOP: begin
                stop_o <= bit_i;
                done_o <= 1'b1;
                busy_o <= 1'b0;
                state  <= RX_IDLE;
              end
              default: ;
            endcase
          end
          if (phase_o == PH_LAST) begin
            if (state == RX_START) state <= RX_DATA;
            else if (state == RX_DATA && cnt == nbits) state <= RX_STOP;
          end
        end
      end
    end
  end

  AST_DONE_DROPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
  AST_IDLE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == RX_IDLE) |-> !busy_o); // R6
endmodule

// File: rtl/rx_status.sv
module rx_status #(
  parameter int DATA_W = 8,
  parameter int FRM_W  = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [FRM_W-1:0]  bits_i,
  input  logic              stop_i,
  input  logic              nine_bit_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              full_o,
  output logic              fe_o,
  output logic              brk_o,
  output logic              ovr_o
);
  logic b9, all_zero, is_brk;

  assign b9       = nine_bit_i & bits_i[DATA_W];
  assign all_zero = (bits_i[DATA_W-1:0] == '0) && !b9;
  assign is_brk   = !stop_i && all_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      bit9_o <= 1'b0;
      full_o <= 1'b0;
      fe_o   <= 1'b0;
      brk_o  <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (ack_i) begin
        full_o <= 1'b0;
        fe_o   <= 1'b0;
        brk_o  <= 1'b0;
        ovr_o  <= 1'b0;
      end
      if (done_i) begin
        if (full_o && !ack_i) begin
          ovr_o <= 1'b1;  // earlier frame kept
        end else begin
          full_o <= 1'b1;
          data_o <= is_brk ? '0 : bits_i[DATA_W-1:0];
          bit9_o <= is_brk ? 1'b0 : b9;
          fe_o   <= !stop_i;
          brk_o  <= is_brk;
        end
      end
    end
  end

  AST_DONE_SETS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> full_o); // R2
  AST_BRK_SETS_FE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (fe_o && full_o)); // R5
  AST_BRK_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (data_o == '0 && !bit9_o)); // R5
  AST_OVR_HOLDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full_o && !ack_i) |=>
      (ovr_o && $stable(data_o) && $stable(bit9_o) && $stable(brk_o) && $stable(fe_o))); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !done_i) |=> (!full_o && !fe_o && !brk_o && !ovr_o)); // R8
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx #(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              nine_bit_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              full_o,
  output logic              frame_err_o,
  output logic              brk_o,
  output logic              ovr_o,
  output logic              busy_o
);
  localparam int PH_W  = $clog2(OVS);
  localparam int FRM_W = DATA_W + 1;

  logic             rxd_s;
  logic [PH_W-1:0]  phase;
  logic             vld, vbit;
  logic             done, stop;
  logic [FRM_W-1:0] bits;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  rx_vote #(.OVS(OVS), .PH_W(PH_W)) u_vote (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .phase_i(phase),
    .rxd_i  (rxd_s),
    .vld_o  (vld),
    .bit_o  (vbit)
  );

  rx_frame #(.OVS(OVS), .DATA_W(DATA_W), .PH_W(PH_W), .FRM_W(FRM_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rxd_i     (rxd_s),
    .nine_bit_i(nine_bit_i),
    .vld_i     (vld),
    .bit_i     (vbit),
    .phase_o   (phase),
    .busy_o    (busy_o),
    .done_o    (done),
    .stop_o    (stop),
    .bits_o    (bits)
  );

  rx_status #(.DATA_W(DATA_W), .FRM_W(FRM_W)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .bits_i    (bits),
    .stop_i    (stop),
    .nine_bit_i(nine_bit_i),
    .ack_i     (ack_i),
    .data_o    (data_o),
    .bit9_o    (bit9_o),
    .full_o    (full_o),
    .fe_o      (frame_err_o),
    .brk_o     (brk_o),
    .ovr_o     (ovr_o)
  );
endmodule

// File: tb/uart_brk_rx_bench.sv
module uart_brk_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 16;
  localparam int NVEC       = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b1;
  logic       rxd = 1'b1;
  logic       nine = 1'b0;
  logic       ack = 1'b0;
  logic [7:0] data;
  logic       bit9, full, fe, brk, ovr, busy;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_brk_rx #(.OVS(OVS), .DATA_W(8), .SYNC_STAGES(2)) u_uart_brk_rx (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .rxd_i      (rxd),
    .nine_bit_i (nine),
    .ack_i      (ack),
    .data_o     (data),
    .bit9_o     (bit9),
    .full_o     (full),
    .frame_err_o(fe),
    .brk_o      (brk),
    .ovr_o      (ovr),
    .busy_o     (busy)
  );

  // {nine, stop, din[8:0], exp_data[7:0], exp_b9, exp_fe, exp_brk}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 9'h0A5, 8'hA5, 1'b0, 1'b0, 1'b0},  // R2 normal
    {1'b0, 1'b1, 9'h000, 8'h00, 1'b0, 1'b0, 1'b0},  // R9 zero data
    {1'b0, 1'b0, 9'h03C, 8'h3C, 1'b0, 1'b1, 1'b0},  // R4 framing error
    {1'b0, 1'b0, 9'h000, 8'h00, 1'b0, 1'b1, 1'b1},  // R5 break 8-bit
    {1'b1, 1'b1, 9'h1FF, 8'hFF, 1'b1, 1'b0, 1'b0},  // R2 nine bit
    {1'b1, 1'b0, 9'h100, 8'h00, 1'b1, 1'b1, 1'b0},  // R4 ninth bit defeats break
    {1'b1, 1'b0, 9'h000, 8'h00, 1'b0, 1'b1, 1'b1},  // R5 break 9-bit
    {1'b0, 1'b1, 9'h180, 8'h80, 1'b0, 1'b0, 1'b0}   // R2 bit 8 unused in 8-bit mode
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic v, input bit glitch);
    for (int k = 0; k < OVS; k++) begin
      @(negedge clk);
      rxd = (glitch && k == OVS / 2) ? ~v : v;
    end
  endtask

  task automatic send(input logic [8:0] d, input bit nb9, input logic stop, input bit glitch);
    int nb;
    nb = nb9 ? 9 : 8;
    nine = nb9;
    put_bit(1'b0, glitch);
    for (int i = 0; i < nb; i++) put_bit(d[i], glitch);
    put_bit(stop, glitch);
    for (int k = 0; k < 2 * OVS; k++) begin
      @(negedge clk);
      rxd = 1'b1;
    end
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 data", 32'(data), 32'h0);
    chk("R1 flags", {bit9, full, fe, brk, ovr, busy}, 6'b0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      do_ack();
      send(VEC[v][19:11], VEC[v][21], VEC[v][20], 1'b0);
      chk($sformatf("R2 full vec%0d", v), 32'(full), 32'h1);
      chk($sformatf("R2/R9 data vec%0d", v), 32'(data), 32'(VEC[v][10:3]));
      chk($sformatf("R2 bit9 vec%0d", v), 32'(bit9), 32'(VEC[v][2]));
      chk($sformatf("R4 fe vec%0d", v), 32'(fe), 32'(VEC[v][1]));
      chk($sformatf("R5 brk vec%0d", v), 32'(brk), 32'(VEC[v][0]));
      chk($sformatf("R6 idle busy vec%0d", v), 32'(busy), 32'h0);
    end

    // R3 single inverted sample in every bit
    do_ack();
    send(9'h0A5, 1'b0, 1'b1, 1'b1);
    chk("R3 glitch data", 32'(data), 32'hA5);
    chk("R3 glitch fe", 32'(fe), 32'h0);

    // R3/R6 rejected start pulse
    do_ack();
    @(negedge clk);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * OVS) @(negedge clk);
    chk("R3 false start full", 32'(full), 32'h0);
    chk("R6 false start busy", 32'(busy), 32'h0);

    // R6 busy mid-frame
    fork
      send(9'h05A, 1'b0, 1'b1, 1'b0);
      begin
        repeat (OVS * 4) @(negedge clk);
        chk("R6 busy mid-frame", 32'(busy), 32'h1);
      end
    join
    chk("R6 busy after stop", 32'(busy), 32'h0);

    // R7 overrun keeps first frame
    do_ack();
    send(9'h011, 1'b0, 1'b1, 1'b0);
    send(9'h022, 1'b0, 1'b1, 1'b0);
    chk("R7 ovr", 32'(ovr), 32'h1);
    chk("R7 data kept", 32'(data), 32'h11);
    send(9'h000, 1'b0, 1'b0, 1'b0);
    chk("R7 break during overrun brk", 32'(brk), 32'h0);
    chk("R7 break during overrun fe", 32'(fe), 32'h0);

    // R8 ack clears
    do_ack();
    chk("R8 ack clears", {full, fe, brk, ovr}, 4'b0);
    send(9'h000, 1'b0, 1'b0, 1'b0);
    chk("R5 break flags", {full, fe, brk}, 3'b111);
    do_ack();
    chk("R8 ack clears break", {full, fe, brk, ovr}, 4'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule